// File: doc/BRIEF.md
# Background CRC Coprocessor

This block is a 32-bit CRC engine that sits beside a processor and is driven through a custom-instruction style port. Each instruction carries a two-bit sub-opcode, two 32-bit operands and a one-cycle `start` strobe. The block answers every instruction with a one-cycle `done` strobe. The generator polynomial and the start value can both be programmed. Data words of 1 to 32 bits are shifted into the running remainder.

An insert is accepted at once when the engine is idle. The engine then works through the bits one per clock while the processor carries on with other work. The processor is held back only when it issues a second insert, or a read, while bits are still being consumed. A load of a new start value is never held back and abandons any insert that is still running.

Top module: `crc_coproc`

## Requirements
- R1: The sub-opcode `sel` selects the operation: 0 sets the polynomial, 1 loads a start value, 2 inserts data and 3 reads the CRC. An instruction is a one-cycle `start` pulse with `sel`, `opa` and `opb` valid in that cycle.
- R2: A set-polynomial takes `opa` as the generator without the implicit x^32 term. `done` rises in the cycle after the `start` pulse.
- R3: Each data bit b updates the remainder as follows: f = crc[31] xor b, then crc = (crc << 1) xor (f ? poly : 0). Exactly one bit is consumed per clock, and the remainder changes only while bits are being consumed or on a load.
- R4: An insert takes its data from `opa` and its bit count n from `opb`. The bits are consumed from bit n-1 down to bit 0, and bits above n-1 are ignored. A count of 0, or any count above 32, is treated as 32.
- R5: An insert issued to an idle engine raises `done` in the next cycle, and the bits are then consumed in the background.
- R6: An insert issued while the engine is busy is accepted only after the engine becomes idle. For a back-to-back insert after an n-bit insert, `done` arrives n+1 cycles after the second `start` is sampled.
- R7: A read returns the CRC on `result` in the same cycle as `done`. On an idle engine this happens one cycle after `start`. A read issued right behind an n-bit insert waits and returns the final value n+1 cycles after its `start` is sampled.
- R8: A load-start sets the remainder to `opa` and raises `done` in the next cycle, even while the engine is busy. It abandons the running insert.
- R9: `done` is low after reset and pulses for exactly one cycle per instruction. The host issues no new `start` while an instruction is still waiting for its `done`. After reset, `result` is 0 and the remainder is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle instruction strobe |
| sel | input | 2 | Sub-opcode |
| opa | input | 32 | Operand A: polynomial, start value or data |
| opb | input | 32 | Operand B: bit count for an insert |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | CRC value returned by a read |

## Verification
The assertions check, on every cycle, the bookkeeping of the bit counter. They also check that inserts and reads are accepted only by an idle engine, that a load or a polynomial write completes in one cycle, and that the remainder stays still whenever no bits are being consumed. Whether the remainder is arithmetically correct can only be shown by the bench. It does this with known check values, random data words of random length under random polynomials, the count clamp, and the exact stall latencies of colliding instructions.

// File: rtl/crc_coproc_pkg.sv
package crc_coproc_pkg;
  typedef enum logic [1:0] {
    OP_SETPOLY   = 2'd0,
    OP_LOADSTART = 2'd1,
    OP_INSERT    = 2'd2,
    OP_READ      = 2'd3
  } crc_op_e;
endpackage

// File: rtl/crc_cmd_hold.sv
module crc_cmd_hold import crc_coproc_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         accept,
  output logic         cmd_v,
  output crc_op_e      cmd_op,
  output logic [W-1:0] cmd_a,
  output logic [W-1:0] cmd_b
);
  logic         pend_v;
  crc_op_e      pend_op;
  logic [W-1:0] pend_a, pend_b;

  assign cmd_v  = start | pend_v;
  assign cmd_op = start ? crc_op_e'(sel) : pend_op;
  assign cmd_a  = start ? opa : pend_a;
  assign cmd_b  = start ? opb : pend_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_op <= OP_SETPOLY;
      pend_a  <= '0;
      pend_b  <= '0;
    end else if (start && !accept) begin
      pend_v  <= 1'b1;
      pend_op <= crc_op_e'(sel);
      pend_a  <= opa;
      pend_b  <= opb;
    end else if (accept) begin
      pend_v  <= 1'b0;
    end
  end

  AST_NO_START_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> !start); // R9
endmodule

// File: rtl/crc_bit_engine.sv
module crc_bit_engine #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  poly,
  input  logic          load_en,
  input  logic [W-1:0]  load_val,
  input  logic          ins_en,
  input  logic [W-1:0]  ins_data,
  input  logic [CW-1:0] ins_cnt,
  output logic [W-1:0]  crc,
  output logic          busy
);
  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;

  function automatic logic [W-1:0] crc_bit(input logic [W-1:0] c,
                                           input logic b,
                                           input logic [W-1:0] p);
    logic fb;
    fb = c[W-1] ^ b;
    return {c[W-2:0], 1'b0} ^ (fb ? p : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc  <= '0;
      sreg <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load_en) begin
      crc  <= load_val;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (ins_en) begin
      sreg <= ins_data << (W - int'(ins_cnt));
      cnt  <= ins_cnt;
      busy <= 1'b1;
    end else if (busy) begin
      crc  <= crc_bit(crc, sreg[W-1], poly);
      sreg <= {sreg[W-2:0], 1'b0};
      cnt  <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= CW'(1) && cnt <= CW'(W))); // R3
  AST_CNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt > CW'(1) && !load_en) |=> (busy && cnt == $past(cnt) - CW'(1))); // R3
  AST_LAST_BIT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == CW'(1)) |=> !busy); // R3
  AST_CRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load_en) |=> $stable(crc)); // R3
endmodule

// File: rtl/crc_coproc.sv
module crc_coproc import crc_coproc_pkg::*; #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   sel,
  input  logic [31:0]  opa,
  input  logic [31:0]  opb,
  output logic         done,
  output logic [31:0]  result
);
  logic          cmd_v, accept, eng_busy;
  crc_op_e       cmd_op;
  logic [W-1:0]  cmd_a, cmd_b, poly, crc;
  logic          ins_accept, rd_accept, ld_accept, poly_accept;

  function automatic logic [CW-1:0] clamp_cnt(input logic [W-1:0] b);
    return (b == '0 || b > W) ? CW'(W) : b[CW-1:0];
  endfunction

  crc_cmd_hold #(.W(W)) i_hold (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .opa(opa), .opb(opb),
    .accept(accept), .cmd_v(cmd_v), .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b)
  );

  always_comb begin
    unique case (cmd_op)
      OP_SETPOLY, OP_LOADSTART: accept = cmd_v;
      default:                  accept = cmd_v & ~eng_busy;
    endcase
  end

  assign poly_accept = accept && cmd_op == OP_SETPOLY;
  assign ld_accept   = accept && cmd_op == OP_LOADSTART;
  assign ins_accept  = accept && cmd_op == OP_INSERT;
  assign rd_accept   = accept && cmd_op == OP_READ;

  crc_bit_engine #(.W(W)) i_eng (
    .clk(clk), .rst_n(rst_n), .poly(poly),
    .load_en(ld_accept), .load_val(cmd_a),
    .ins_en(ins_accept), .ins_data(cmd_a), .ins_cnt(clamp_cnt(cmd_b)),
    .crc(crc), .busy(eng_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      poly   <= '0;
      result <= '0;
    end else begin
      done <= accept;
      if (poly_accept) poly   <= cmd_a;
      if (rd_accept)   result <= crc;
    end
  end

  AST_INSERT_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_accept |-> !eng_busy); // R6
  AST_READ_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |-> !eng_busy); // R7
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel == 2'd1) |=> done); // R8
  AST_POLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel == 2'd0) |=> (done && poly == $past(opa))); // R2
  AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({poly_accept, ld_accept, ins_accept, rd_accept})); // R1
endmodule

// File: tb/test_crc_coproc.sv
module test_crc_coproc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  sel = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        done;
  logic [31:0] result;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_poly = '0, m_crc = '0;

  always #5 clk = ~clk;

  crc_coproc i_crc_coproc (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .opa(opa), .opb(opb),
    .done(done), .result(result)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] p,
                                          input logic [31:0] d, input logic [31:0] n);
    int nn;
    logic top;
    nn = (n == 0 || n > 32) ? 32 : int'(n);
    for (int i = nn - 1; i >= 0; i--) begin
      top = c[31] ^ d[i];
      c = {c[30:0], 1'b0};
      if (top) c = c ^ p;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       output int k);
    start = 1'b1; sel = op; opa = a; opb = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 300) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R9: no done, actual %0d expected <300 cycles", k);
    end
    case (op)
      2'd0: m_poly = a;
      2'd1: m_crc = a;
      2'd2: m_crc = ref_crc(m_crc, m_poly, a, b);
      default: ;
    endcase
  endtask

  task automatic rd_check(input string req);
    int k;
    issue(2'd3, 32'h0, 32'h0, k);
    check(req, result, m_crc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R9 reset done", {31'b0, done}, 32'h0);
    check("R9 reset result", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: idle read returns reset remainder in one cycle
    issue(2'd3, 0, 0, k);
    check("R7 idle read latency", k, 1);
    check("R7 read after reset", result, 32'h0);
    // R9: done low again when no new start
    @(negedge clk);
    check("R9 done one cycle", {31'b0, done}, 32'h0);

    // R2 + R3: known check string, 32-bit polynomial, all-ones start
    issue(2'd0, 32'h04C11DB7, 0, k);
    check("R2 poly latency", k, 1);
    issue(2'd1, 32'hFFFFFFFF, 0, k);
    for (int c = 8'h31; c <= 8'h39; c++) issue(2'd2, c, 8, k);
    issue(2'd3, 0, 0, k);
    check("R3 check value 32-bit", result, 32'h0376E6E7);

    // R3: 16-bit generator aligned to the top
    issue(2'd0, 32'h10210000, 0, k);
    issue(2'd1, 32'h0, 0, k);
    for (int c = 8'h31; c <= 8'h39; c++) issue(2'd2, c, 8, k);
    issue(2'd3, 0, 0, k);
    check("R3 check value 16-bit", result, 32'h31C30000);

    // R5 + R7: idle insert is accepted in one cycle, read right behind waits n+1
    issue(2'd0, 32'h1EDC6F41, 0, k);
    issue(2'd1, 32'h12345678, 0, k);
    issue(2'd2, 32'hABCDE, 20, k);
    check("R5 idle insert latency", k, 1);
    issue(2'd3, 0, 0, k);
    check("R7 stalled read latency", k, 21);
    check("R7 stalled read value", result, m_crc);

    // R6: insert behind a busy 32-bit insert
    issue(2'd2, 32'hDEADBEEF, 32, k);
    issue(2'd2, 32'h0F0F1234, 32, k);
    check("R6 stalled insert latency", k, 33);
    rd_check("R6 value after two inserts");

    // R5: background run finished before read; read costs one cycle
    issue(2'd2, 32'hCAFEF00D, 32, k);
    repeat (40) @(negedge clk);
    issue(2'd3, 0, 0, k);
    check("R5 background read latency", k, 1);
    check("R5 background value", result, m_crc);

    // R8: load aborts a running insert
    issue(2'd2, 32'h55AA55AA, 32, k);
    issue(2'd1, 32'h87654321, 0, k);
    check("R8 load latency while busy", k, 1);
    issue(2'd3, 0, 0, k);
    check("R8 load aborts insert", result, 32'h87654321);

    // R4: clamp of 0 and of counts above 32, and upper bits ignored
    issue(2'd2, 32'h13579BDF, 0, k);
    rd_check("R4 count 0 as 32");
    issue(2'd2, 32'h2468ACE0, 45, k);
    rd_check("R4 count 45 as 32");
    issue(2'd1, 32'h0000_0000, 0, k);
    issue(2'd2, 32'hFFFFFFF5, 4, k);
    issue(2'd3, 0, 0, k);
    check("R4 upper bits ignored", result, ref_crc(32'h0, m_poly, 32'h5, 4));
    issue(2'd2, 32'h1, 1, k);
    rd_check("R4 single bit");

    // R1 R3 R4: random mix
    for (int it = 0; it < 60; it++) begin
      int pick;
      pick = int'($urandom % 8);
      if (pick == 0) begin
        rd_check("R1 random read before poly");
        issue(2'd0, $urandom, 0, k);
      end else if (pick == 1) begin
        rd_check("R1 random read before load");
        issue(2'd1, $urandom, 0, k);
      end else begin
        issue(2'd2, $urandom, $urandom % 41, k);
        repeat ($urandom % 40) @(negedge clk);
        if (pick > 4) rd_check("R3 random insert");
      end
    end
    rd_check("R3 random final");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule